// File: doc/BRIEF.md
# Compare Flags and Branch Resolver

This block holds the five-bit condition state of a small processor core and uses it to settle conditional branches. A compare strobe loads the state from two 32-bit operands. One compare records both the signed and the unsigned relation between the operands. Each branch then tests one flag, or the union of two flags, instead of deriving a relation from arithmetic carry and overflow flags.

A branch strobe presents an 8-bit opcode, the address of the branch and the 32-bit absolute target word that follows the opcode word. One cycle later the block reports whether the branch is taken, the next PC, and whether the opcode was one it does not handle. The condition register sits in its own always_ff. The result channel is a two-state machine with these states:
- `RS_IDLE`: no result is pending.
- `RS_RESULT`: a result was produced in the previous cycle, and `br_valid` is high.

Its transitions are:
- `GO_RESOLVE`: `br_go` in either state moves the machine to `RS_RESULT`.
- `GO_REST`: no `br_go` while in `RS_RESULT` returns the machine to `RS_IDLE`.

Top module: `cmpbr_resolver`

## Requirements
- R1: After reset, `flags_q` is 0 and `br_valid`, `br_taken` and `br_illegal` are 0.
- R2: A compare of equal operands sets `flags_q` to 5'b00100 at the next clock edge. Bit 2 (EQ) is the only bit set.
- R3: A compare of unequal operands clears bit 2 and sets four relation bits. Bit 1 means a is less than b as signed. Bit 0 means a is greater than b as signed. Bit 4 means a is less than b as unsigned. Bit 3 means a is greater than b as unsigned.
- R4: `flags_q` changes only in the cycle after `cmp_go` is high. Branches, including illegal ones, leave it unchanged.
- R5: Branch opcodes 8'h0F through 8'h18 take, in this order: EQ; not EQ; LT; GT; LTU; GTU; GT or EQ; LT or EQ; GTU or EQ; LTU or EQ.
- R6: A taken branch sets `br_next_pc` to `br_tgt`.
- R7: A legal branch that is not taken sets `br_next_pc` to `br_pc` + 6.
- R8: An opcode outside 8'h0F..8'h18 gives `br_illegal` = 1 and `br_taken` = 0, and `br_next_pc` equals `br_pc`.
- R9: The branch results appear one cycle after `br_go`, with `br_valid` high for that one cycle. Without `br_go`, the results hold their values and `br_valid` is 0.
- R10: With the flags at their reset value, opcode 8'h10 (not equal) is the only branch taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_go | input | 1 | Compare strobe |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| br_go | input | 1 | Branch strobe. Never high together with `cmp_go` |
| br_op | input | 8 | Branch opcode |
| br_pc | input | 32 | Address of the branch instruction |
| br_tgt | input | 32 | Absolute target word |
| flags_q | output | 5 | Condition flags: {LTU, GTU, EQ, LT, GT} |
| br_valid | output | 1 | Result strobe, one cycle after `br_go` |
| br_taken | output | 1 | Branch taken |
| br_next_pc | output | 32 | Next PC |
| br_illegal | output | 1 | Opcode not handled by this block |

## Verification
The assertions check several properties on every cycle:
- Flags stay stable without a compare.
- An equal compare leaves only EQ set.
- The signed pair of bits is never set together, and neither is the unsigned pair.
- An illegal result is never taken.
- The next PC matches the target or the 6-byte step, according to the taken signal.
- `br_valid` follows `br_go` by exactly one cycle.

Only the bench scenarios can show that each of the ten opcodes tests the right union of flags. They also show that mixed-sign operand pairs set the right combination of signed and unsigned bits, and that only the not-equal branch is taken right after reset.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;
    localparam int FLAG_W  = 5;
    localparam int F_GT    = 0;
    localparam int F_LT    = 1;
    localparam int F_EQ    = 2;
    localparam int F_GTU   = 3;
    localparam int F_LTU   = 4;
    localparam int KIND_N  = 10;
    localparam int KIND_W  = $clog2(KIND_N);

    typedef enum logic [KIND_W-1:0] {
        BK_EQ, BK_NE, BK_LT, BK_GT, BK_LTU,
        BK_GTU, BK_GE, BK_LE, BK_GEU, BK_LEU
    } br_kind_e;

    typedef enum logic {
        RS_IDLE,
        RS_RESULT
    } res_state_e;
endpackage

// File: rtl/cmpbr_compare.sv
module cmpbr_compare
    import cmpbr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [FLAG_W-1:0] flags_d
);
    logic same, s_lt, s_gt, u_lt, u_gt;

    always_comb begin
        same = (op_a == op_b);
        s_lt = ($signed(op_a) < $signed(op_b));
        s_gt = ($signed(op_a) > $signed(op_b));
        u_lt = (op_a < op_b);
        u_gt = (op_a > op_b);
        flags_d = '0;
        if (same) begin
            flags_d[F_EQ] = 1'b1;
        end else begin
            flags_d[F_LT]  = s_lt;
            flags_d[F_GT]  = s_gt;
            flags_d[F_LTU] = u_lt;
            flags_d[F_GTU] = u_gt;
        end
    end
endmodule

// File: rtl/cmpbr_cond_eval.sv
module cmpbr_cond_eval
    import cmpbr_pkg::*;
#(
    parameter int         OP_W    = 8,
    parameter logic [7:0] OP_BASE = 8'h0F
) (
    input  logic [OP_W-1:0]   op,
    input  logic [FLAG_W-1:0] flags,
    output logic              take,
    output logic              illegal
);
    logic [OP_W-1:0] offs;
    br_kind_e        kind;
    logic            in_range;

    always_comb begin
        offs     = op - OP_W'(OP_BASE);
        in_range = (op >= OP_W'(OP_BASE)) && (offs < OP_W'(KIND_N));
        kind     = br_kind_e'(offs[KIND_W-1:0]);
        illegal  = !in_range;
        take     = 1'b0;
        if (in_range) begin
            unique case (kind)
                BK_EQ:   take = flags[F_EQ];
                BK_NE:   take = !flags[F_EQ];
                BK_LT:   take = flags[F_LT];
                BK_GT:   take = flags[F_GT];
                BK_LTU:  take = flags[F_LTU];
                BK_GTU:  take = flags[F_GTU];
                BK_GE:   take = flags[F_GT]  | flags[F_EQ];
                BK_LE:   take = flags[F_LT]  | flags[F_EQ];
                BK_GEU:  take = flags[F_GTU] | flags[F_EQ];
                BK_LEU:  take = flags[F_LTU] | flags[F_EQ];
                default: take = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cmpbr_pc_sel.sv
module cmpbr_pc_sel #(
    parameter int ADDR_W     = 32,
    parameter int STEP_BYTES = 6
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] tgt,
    input  logic              take,
    input  logic              illegal,
    output logic [ADDR_W-1:0] next_pc
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

    always_comb begin
        if (illegal)   next_pc = pc;
        else if (take) next_pc = tgt;
        else           next_pc = pc + STEP;
    end
endmodule

// File: rtl/cmpbr_resolver.sv
module cmpbr_resolver
    import cmpbr_pkg::*;
#(
    parameter int         DATA_W     = 32,
    parameter int         ADDR_W     = 32,
    parameter int         OP_W       = 8,
    parameter int         STEP_BYTES = 6,
    parameter logic [7:0] OP_BASE    = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_go,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic              br_go,
    input  logic [OP_W-1:0]   br_op,
    input  logic [ADDR_W-1:0] br_pc,
    input  logic [ADDR_W-1:0] br_tgt,
    output logic [FLAG_W-1:0] flags_q,
    output logic              br_valid,
    output logic              br_taken,
    output logic [ADDR_W-1:0] br_next_pc,
    output logic              br_illegal
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

    logic [FLAG_W-1:0] flags_d;
    logic              take_d, ill_d;
    logic [ADDR_W-1:0] npc_d;
    res_state_e        st_q, st_d;

    cmpbr_compare #(.DATA_W(DATA_W)) u_cmp (
        .op_a(cmp_a), .op_b(cmp_b), .flags_d(flags_d)
    );

    cmpbr_cond_eval #(.OP_W(OP_W), .OP_BASE(OP_BASE)) u_cond (
        .op(br_op), .flags(flags_q), .take(take_d), .illegal(ill_d)
    );

    cmpbr_pc_sel #(.ADDR_W(ADDR_W), .STEP_BYTES(STEP_BYTES)) u_pcs (
        .pc(br_pc), .tgt(br_tgt), .take(take_d), .illegal(ill_d), .next_pc(npc_d)
    );

    // Condition register: loaded only by a compare
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flags_q <= '0;
        else if (cmp_go) flags_q <= flags_d;
    end

    // Result channel state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RS_IDLE:   if (br_go) st_d = RS_RESULT;
            RS_RESULT: if (!br_go) st_d = RS_IDLE;
            default:   st_d = RS_IDLE;
        endcase
    end

    // Result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            br_taken   <= 1'b0;
            br_illegal <= 1'b0;
            br_next_pc <= '0;
        end else if (br_go) begin
            br_taken   <= take_d;
            br_illegal <= ill_d;
            br_next_pc <= npc_d;
        end
    end

    assign br_valid = (st_q == RS_RESULT);

    AST_EQ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_go && cmp_a == cmp_b) |=> (flags_q == 5'b00100)); // R2
    AST_REL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags_q[F_LT] && flags_q[F_GT]) && !(flags_q[F_LTU] && flags_q[F_GTU])); // R3
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_go |=> $stable(flags_q)); // R4
    AST_TAKEN_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_taken) |-> (br_next_pc == $past(br_tgt))); // R6
    AST_STEP_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !br_taken && !br_illegal) |-> (br_next_pc == $past(br_pc) + STEP)); // R7
    AST_ILL_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        br_illegal |-> !br_taken); // R8
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        br_go |=> br_valid); // R9
    AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !br_go |=> !br_valid); // R9
endmodule

// File: tb/cmpbr_resolver_bench.sv
`timescale 1ns/1ps
module cmpbr_resolver_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_go = 1'b0;
    logic [31:0] cmp_a = '0, cmp_b = '0;
    logic        br_go = 1'b0;
    logic [7:0]  br_op = '0;
    logic [31:0] br_pc = '0, br_tgt = '0;
    logic [4:0]  flags_q;
    logic        br_valid, br_taken, br_illegal;
    logic [31:0] br_next_pc;

    int checks = 0;
    int errors = 0;
    logic [4:0] mflags = '0;

    always #2.5 clk = ~clk;

    cmpbr_resolver u_cmpbr_resolver (
        .clk(clk), .rst_n(rst_n), .cmp_go(cmp_go), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .br_go(br_go), .br_op(br_op), .br_pc(br_pc), .br_tgt(br_tgt),
        .flags_q(flags_q), .br_valid(br_valid), .br_taken(br_taken),
        .br_next_pc(br_next_pc), .br_illegal(br_illegal)
    );

    function automatic logic [4:0] exp_flags(input logic [31:0] a, input logic [31:0] b);
        logic [4:0] f;
        f = '0;
        if (a == b) f[2] = 1'b1;
        else begin
            f[1] = $signed(a) < $signed(b);
            f[0] = $signed(a) > $signed(b);
            f[4] = a < b;
            f[3] = a > b;
        end
        return f;
    endfunction

    function automatic logic exp_take(input logic [7:0] op, input logic [4:0] f);
        case (op)
            8'h0F: return f[2];
            8'h10: return !f[2];
            8'h11: return f[1];
            8'h12: return f[0];
            8'h13: return f[4];
            8'h14: return f[3];
            8'h15: return f[0] | f[2];
            8'h16: return f[1] | f[2];
            8'h17: return f[3] | f[2];
            8'h18: return f[4] | f[2];
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_cmp(input logic [31:0] a, input logic [31:0] b, input string req);
        @(negedge clk);
        cmp_a = a; cmp_b = b; cmp_go = 1'b1;
        @(negedge clk);
        cmp_go = 1'b0;
        mflags = exp_flags(a, b);
        chk(req, 32'(flags_q), 32'(mflags));
    endtask

    task automatic do_br(input logic [7:0] op, input logic [31:0] pc, input logic [31:0] tgt,
                         input string req);
        logic legal, tk;
        logic [31:0] npc;
        legal = (op >= 8'h0F) && (op <= 8'h18);
        tk = legal && exp_take(op, mflags);
        npc = !legal ? pc : (tk ? tgt : pc + 32'd6);
        @(negedge clk);
        br_op = op; br_pc = pc; br_tgt = tgt; br_go = 1'b1;
        @(negedge clk);
        br_go = 1'b0;
        br_op = ~op; br_pc = ~pc; br_tgt = ~tgt;
        chk({req, " valid R9"}, 32'(br_valid), 32'd1);
        chk({req, " taken R5"}, 32'(br_taken), 32'(tk));
        chk({req, " illegal R8"}, 32'(br_illegal), 32'(!legal));
        chk(tk ? {req, " pc R6"} : (legal ? {req, " pc R7"} : {req, " pc R8"}), br_next_pc, npc);
        chk({req, " flags kept R4"}, 32'(flags_q), 32'(mflags));
        @(negedge clk);
        chk({req, " valid drop R9"}, 32'(br_valid), 32'd0);
        chk({req, " hold R9"}, br_next_pc, npc);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed_v;
        seed_v = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 flags", 32'(flags_q), 32'd0);
        chk("R1 valid", 32'(br_valid), 32'd0);
        chk("R1 taken", 32'(br_taken), 32'd0);
        chk("R1 illegal", 32'(br_illegal), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: with zero flags only 0x10 is taken
        for (int op = 8'h0F; op <= 8'h18; op++)
            do_br(8'(op), 32'h0000_1000 + 32'(op) * 16, 32'h0000_8000, "R10");
        // R2 / R3 directed corners
        do_cmp(32'h1234_5678, 32'h1234_5678, "R2 equal");
        for (int op = 8'h0F; op <= 8'h18; op++)
            do_br(8'(op), 32'h0000_2000, 32'h0000_4000, "R5 eq flags");
        do_cmp(32'hFFFF_FFFF, 32'h0000_0001, "R3 neg vs pos");
        for (int op = 8'h0F; op <= 8'h18; op++)
            do_br(8'(op), 32'hFFFF_FFFC, 32'h0000_0040, "R5 mixed");
        do_cmp(32'h8000_0000, 32'h7FFF_FFFF, "R3 min vs max");
        do_cmp(32'h0000_0003, 32'h0000_0009, "R3 small");
        for (int op = 8'h0F; op <= 8'h18; op++)
            do_br(8'(op), 32'h0000_0100, 32'hABCD_0000, "R5 less");
        do_cmp(32'h0000_0000, 32'h0000_0000, "R2 zero");
        // R8 illegal opcodes
        do_br(8'h0E, 32'h0000_0300, 32'h0000_0500, "R8 below");
        do_br(8'h19, 32'h0000_0300, 32'h0000_0500, "R8 above");
        do_br(8'hFF, 32'h0000_0300, 32'h0000_0500, "R8 top");
        do_br(8'h00, 32'h0000_0300, 32'h0000_0500, "R8 zero");
        // R4: idle cycles leave flags alone
        repeat (4) @(negedge clk);
        chk("R4 idle", 32'(flags_q), 32'(mflags));
        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            logic [7:0]  op;
            a = $urandom();
            b = ($urandom() % 4 == 0) ? a : $urandom();
            if ($urandom() % 3 == 0) b = {a[31:1], ~a[0]};
            do_cmp(a, b, "R3 random");
            op = ($urandom() % 8 == 0) ? 8'($urandom()) : 8'(8'h0F + $urandom() % 10);
            do_br(op, $urandom(), $urandom(), "R5 random");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule